// File: doc/BRIEF.md
# External Bus Recovery Cycle Inserter

This block sits between an external bus access sequencer and the pins of the external bus. It holds six chip-select configuration words. Each word carries two 4-bit recovery counts: one that applies after a write and one that applies after a read. When the sequencer reports that an external access has completed, the block records three things: whether that access was a read or a write, which chip select it used, and the matching recovery count. It then starts counting the cycles that pass until the next access.

The sequencer raises a request for the next access and states its direction. The block answers on a combinational grant line. The grant is held low only when the new access is in the opposite direction to the last completed one and fewer cycles have passed since that completion than the recorded count. Idle cycles spent before the request is raised therefore count toward the recovery, and only the shortfall shows up as stall. A repeated access to the same chip select is treated exactly like an access to a different one.

Top module: `bus_recovery_gate`

## Requirements
- R1: Configuration words 0 to 5 are written on a clock edge when `cfg_we` is high, and the word addressed by `cfg_sel` is shown combinationally on `cfg_rdata`. A select value of 6 or 7 writes nothing and reads 0.
- R2: Bits 27:24 of a word hold the post-write recovery count and bits 23:20 hold the post-read recovery count. Both are plain binary, so 0 means no cycles and 1 to 15 mean that many cycles.
- R3: All bits other than 27:20 read as 0, whatever was written to them.
- R4: After reset every count reads 0 and no prior access is recorded, so any request is granted in the same cycle.
- R5: Suppose a write completes in cycle t and the post-write count of its chip select is N. A read request is then not granted before cycle t+1+N, and it is granted from that cycle on.
- R6: R5 applies unchanged when the read uses the same chip select as the write.
- R7: Cycles without a request after a completion count toward the recovery. A read first requested in cycle t+1+k is stalled for max(N-k, 0) cycles.
- R8: After a read completes, a write request is held off in the same way, using the post-read count of the read's chip select.
- R9: A write after a write, or a read after a read, is granted with no recovery stall.
- R10: `acc_grant` is high only while `acc_req` is high.
- R11: The recovery count is captured when the access completes. A configuration write made while the recovery is pending does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_sel` |
| acc_req | input | 1 | Sequencer requests the next external access |
| acc_req_write | input | 1 | Direction of the requested access (1 = write) |
| acc_grant | output | 1 | Requested access may start this cycle |
| acc_done | input | 1 | An external access completes this cycle |
| acc_done_write | input | 1 | Direction of the completing access (1 = write) |
| acc_done_cs | input | 3 | Chip select of the completing access |

## Verification
The bench goes after the exact cycle in which grant returns following a write-to-read or read-to-write turn. It tries this with no idle cycles, with a few idle cycles, and with more idle cycles than the count. A design that ignores idle time would over-stall. An off-by-one counter would release the grant one cycle early or late. A design that uses the count of the next access's chip select, or that applies a count on same-direction accesses, would stall where none is due. It also writes all-ones and out-of-range selects to show that reserved bits and missing words stay 0. It rewrites a pending chip select's count to show that the captured value is the one that is used. A long random mix of accesses, idle gaps and configuration writes then checks the grant against a bench model in every cycle.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
  localparam int unsigned NUM_CS = 6;
  localparam int unsigned CS_W   = 3;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned WR_LSB = 24;
  localparam int unsigned RD_LSB = 20;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t wr_rcv;
    cnt_t rd_rcv;
  } cs_cfg_t;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_t;
endpackage

// File: rtl/rcv_cfg_regs.sv
module rcv_cfg_regs
  import rcv_pkg::*;
#(
  parameter int unsigned N_CS  = NUM_CS,
  parameter int unsigned SEL_W = CS_W,
  parameter int unsigned DW    = REG_W,
  parameter int unsigned WLSB  = WR_LSB,
  parameter int unsigned RLSB  = RD_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output cs_cfg_t          cfg_o [N_CS]
);
  cs_cfg_t cfg_q [N_CS];

  for (genvar ch = 0; ch < N_CS; ch++) begin : g_ch
    logic    wr_en;
    cs_cfg_t cfg_d;

    always_comb begin
      wr_en        = we && (sel == SEL_W'(ch));
      cfg_d.wr_rcv = wdata[WLSB +: CNT_W];
      cfg_d.rd_rcv = wdata[RLSB +: CNT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[ch] <= '0;
      end else if (wr_en) begin
        cfg_q[ch] <= cfg_d;
      end
    end

    assign cfg_o[ch] = cfg_q[ch];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CS; i++) begin
      if (sel == SEL_W'(i)) begin
        rdata[WLSB +: CNT_W] = cfg_q[i].wr_rcv;
        rdata[RLSB +: CNT_W] = cfg_q[i].rd_rcv;
      end
    end
  end
endmodule

// File: rtl/rcv_tracker.sv
module rcv_tracker
  import rcv_pkg::*;
#(
  parameter int unsigned N_CS  = NUM_CS,
  parameter int unsigned SEL_W = CS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             done_write,
  input  logic [SEL_W-1:0] done_cs,
  input  cs_cfg_t          cfg_i [N_CS],
  output logic             prev_valid,
  output acc_kind_t        prev_kind,
  output cnt_t             need_cnt,
  output cnt_t             elapsed
);
  logic      valid_q, valid_d;
  acc_kind_t kind_q, kind_d;
  cnt_t      need_q, need_d;
  cnt_t      elap_q, elap_d;
  logic      elap_sat;
  logic      upd_en;
  cs_cfg_t   sel_cfg;

  always_comb begin
    sel_cfg = '0;
    for (int i = 0; i < N_CS; i++) begin
      if (done_cs == SEL_W'(i)) sel_cfg = cfg_i[i];
    end
  end

  always_comb begin
    elap_sat = (elap_q == {CNT_W{1'b1}});
    upd_en   = done || !elap_sat;
    valid_d  = valid_q;
    kind_d   = kind_q;
    need_d   = need_q;
    elap_d   = elap_q;
    if (done) begin
      valid_d = 1'b1;
      kind_d  = done_write ? ACC_WRITE : ACC_READ;
      need_d  = done_write ? sel_cfg.wr_rcv : sel_cfg.rd_rcv;
      elap_d  = '0;
    end else if (!elap_sat) begin
      elap_d = elap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= ACC_READ;
      need_q  <= '0;
      elap_q  <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      kind_q  <= kind_d;
      need_q  <= need_d;
      elap_q  <= elap_d;
    end
  end

  assign prev_valid = valid_q;
  assign prev_kind  = kind_q;
  assign need_cnt   = need_q;
  assign elapsed    = elap_q;
endmodule

// File: rtl/rcv_grant.sv
module rcv_grant
  import rcv_pkg::*;
(
  input  logic      req,
  input  logic      req_write,
  input  logic      prev_valid,
  input  acc_kind_t prev_kind,
  input  cnt_t      need_cnt,
  input  cnt_t      elapsed,
  output logic      grant
);
  logic turn;
  cnt_t required;

  always_comb begin
    turn     = prev_valid && ((prev_kind == ACC_WRITE) != req_write);
    required = turn ? need_cnt : '0;
    grant    = req && (elapsed >= required);
  end
endmodule

// File: rtl/bus_recovery_gate.sv
module bus_recovery_gate
  import rcv_pkg::*;
#(
  parameter int unsigned N_CS  = NUM_CS,
  parameter int unsigned SEL_W = CS_W,
  parameter int unsigned DW    = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             acc_req,
  input  logic             acc_req_write,
  output logic             acc_grant,
  input  logic             acc_done,
  input  logic             acc_done_write,
  input  logic [SEL_W-1:0] acc_done_cs
);
  cs_cfg_t   cfg_w [N_CS];
  logic      prev_valid;
  acc_kind_t prev_kind;
  cnt_t      need_cnt;
  cnt_t      elapsed;

  rcv_cfg_regs #(
    .N_CS (N_CS),
    .SEL_W(SEL_W),
    .DW   (DW),
    .WLSB (WR_LSB),
    .RLSB (RD_LSB)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .sel  (cfg_sel),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .cfg_o(cfg_w)
  );

  rcv_tracker #(
    .N_CS (N_CS),
    .SEL_W(SEL_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (acc_done),
    .done_write(acc_done_write),
    .done_cs   (acc_done_cs),
    .cfg_i     (cfg_w),
    .prev_valid(prev_valid),
    .prev_kind (prev_kind),
    .need_cnt  (need_cnt),
    .elapsed   (elapsed)
  );

  rcv_grant u_grant (
    .req       (acc_req),
    .req_write (acc_req_write),
    .prev_valid(prev_valid),
    .prev_kind (prev_kind),
    .need_cnt  (need_cnt),
    .elapsed   (elapsed),
    .grant     (acc_grant)
  );
endmodule

// File: rtl/rcv_checker.sv
module rcv_checker
  import rcv_pkg::*;
#(
  parameter int unsigned N_CS  = NUM_CS,
  parameter int unsigned SEL_W = CS_W,
  parameter int unsigned DW    = REG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] cfg_sel,
  input logic [DW-1:0]    cfg_rdata,
  input logic             acc_req,
  input logic             acc_req_write,
  input logic             acc_grant,
  input logic             acc_done,
  input logic             acc_done_write
);
  localparam logic [DW-1:0] FIELD_MASK =
    (DW'({CNT_W{1'b1}}) << WR_LSB) | (DW'({CNT_W{1'b1}}) << RD_LSB);
  localparam int unsigned MAX_STALL = (1 << CNT_W) - 1;

  logic       seen_done;
  logic       last_write;
  logic [7:0] stall_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_done  <= 1'b0;
      last_write <= 1'b0;
      stall_run  <= '0;
    end else begin
      if (acc_done) begin
        seen_done  <= 1'b1;
        last_write <= acc_done_write;
      end
      if (acc_done || !(acc_req && !acc_grant)) stall_run <= '0;
      else                                      stall_run <= stall_run + 8'd1;
    end
  end

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~FIELD_MASK) == '0);

  a_r1_bad_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_sel) >= int'(N_CS)) |-> (cfg_rdata == '0));

  a_r10_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant |-> acc_req);

  a_r4_free_before_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_done && acc_req) |-> acc_grant);

  a_r9_same_kind_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_done && acc_req && (acc_req_write == last_write)) |-> acc_grant);

  a_r5_bounded_stall: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stall_run) <= int'(MAX_STALL));
endmodule

bind bus_recovery_gate rcv_checker #(
  .N_CS (N_CS),
  .SEL_W(SEL_W),
  .DW   (DW)
) u_chk (.*);

// File: tb/tb_bus_recovery_gate.sv
module tb_bus_recovery_gate;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        acc_req;
  logic        acc_req_write;
  logic        acc_grant;
  logic        acc_done;
  logic        acc_done_write;
  logic [2:0]  acc_done_cs;

  bus_recovery_gate dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // bench model
  int wr_f [6];
  int rd_f [6];
  bit m_valid;
  bit m_write;
  int m_need;
  int m_elap;

  function automatic bit exp_grant(bit req, bit rw);
    int need;
    need = (m_valid && (m_write != rw)) ? m_need : 0;
    return req && (m_elap >= need);
  endfunction

  function automatic logic [31:0] exp_rdata(int sel);
    logic [31:0] v;
    v = '0;
    if (sel < 6) begin
      v[27:24] = 4'(wr_f[sel]);
      v[23:20] = 4'(rd_f[sel]);
    end
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic step(bit req, bit rw, bit we, int sel, logic [31:0] wd,
                      bit done, bit dw, int dcs, string tag);
    acc_req        = req;
    acc_req_write  = rw;
    cfg_we         = we;
    cfg_sel        = 3'(sel);
    cfg_wdata      = wd;
    acc_done       = done;
    acc_done_write = dw;
    acc_done_cs    = 3'(dcs);
    #1;
    check(tag, 32'(acc_grant), 32'(exp_grant(req, rw)));
    check("R1 readback", cfg_rdata, exp_rdata(sel));
    @(posedge clk);
    if (done) begin
      m_valid = 1;
      m_write = dw;
      m_need  = (dcs < 6) ? (dw ? wr_f[dcs] : rd_f[dcs]) : 0;
      m_elap  = 0;
    end else if (m_elap < 15) begin
      m_elap++;
    end
    if (we && sel < 6) begin
      wr_f[sel] = int'(wd[27:24]);
      rd_f[sel] = int'(wd[23:20]);
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, 0, 0, 0, tag);
  endtask

  // wait for a grant, counting stall cycles
  task automatic req_until(bit rw, int exp_stall, string tag);
    int st;
    st = 0;
    while (st < 20) begin
      acc_req = 1; acc_req_write = rw; #1;
      if (acc_grant) break;
      step(1, rw, 0, 0, '0, 0, 0, 0, tag);
      st++;
    end
    check({tag, " stall count"}, 32'(st), 32'(exp_stall));
    step(1, rw, 0, 0, '0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int i = 0; i < 6; i++) begin wr_f[i] = 0; rd_f[i] = 0; end
    m_valid = 0; m_write = 0; m_need = 0; m_elap = 0;
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    acc_req = 0; acc_req_write = 0; acc_done = 0; acc_done_write = 0; acc_done_cs = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R4: reset state
    for (int s = 0; s < 8; s++) step(0, 0, 0, s, '0, 0, 0, 0, "R4 reset fields");
    step(1, 0, 0, 0, '0, 0, 0, 0, "R4 free read");
    step(1, 1, 0, 0, '0, 0, 0, 0, "R4 free write");
    step(0, 1, 0, 0, '0, 0, 0, 0, "R10 no req no grant");

    // R2 / R3: field placement and reserved bits
    step(0, 0, 1, 2, 32'hFFFF_FFFF, 0, 0, 0, "R3 write ones");
    step(0, 0, 0, 2, '0, 0, 0, 0, "R3 reserved zero");
    check("R3 ch2 value", cfg_rdata, 32'h0FF0_0000);
    step(0, 0, 1, 1, 32'hA35B_CDEF, 0, 0, 0, "R2 write ch1");
    step(0, 0, 0, 1, '0, 0, 0, 0, "R2 read ch1");
    check("R2 ch1 fields", cfg_rdata, 32'h0350_0000);
    step(0, 0, 1, 6, 32'hFFFF_FFFF, 0, 0, 0, "R1 sel6 write");
    step(0, 0, 0, 6, '0, 0, 0, 0, "R1 sel6 read zero");
    check("R1 sel6 value", cfg_rdata, 32'h0);
    step(0, 0, 1, 4, 32'h0010_0000, 0, 0, 0, "R2 write ch4");

    // R5: write then read, no idle
    step(0, 0, 0, 0, '0, 1, 1, 1, "R5 write done");
    req_until(0, 3, "R5");
    // R6: same chip select for both
    step(0, 0, 0, 0, '0, 1, 1, 2, "R6 write done");
    req_until(0, 15, "R6");
    // R7: idle cycles reduce stall
    step(0, 0, 0, 0, '0, 1, 1, 1, "R7 write done");
    idle(2, "R7 idle");
    req_until(0, 1, "R7");
    step(0, 0, 0, 0, '0, 1, 1, 1, "R7 write done");
    idle(5, "R7 idle long");
    req_until(0, 0, "R7 over");
    // R8: read then write
    step(0, 0, 0, 0, '0, 1, 0, 1, "R8 read done");
    req_until(1, 5, "R8");
    step(0, 0, 0, 0, '0, 1, 0, 4, "R8 read done ch4");
    req_until(1, 1, "R8 ch4");
    // R9: same direction
    step(0, 0, 0, 0, '0, 1, 1, 2, "R9 write done");
    req_until(1, 0, "R9 ww");
    step(0, 0, 0, 0, '0, 1, 0, 2, "R9 read done");
    req_until(0, 0, "R9 rr");
    // R11: config change while pending
    step(0, 0, 0, 0, '0, 1, 1, 1, "R11 write done");
    step(0, 0, 1, 1, 32'h0, 0, 0, 0, "R11 rewrite ch1");
    req_until(0, 2, "R11");
    step(0, 0, 1, 1, 32'h0350_0000, 0, 0, 0, "R11 restore");

    // random mix, grant checked every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit dn;
      r  = int'($urandom_range(0, 99));
      dn = (r < 20);
      step(($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1),
           (r >= 95), int'($urandom_range(0, 7)), $urandom(),
           dn, ($urandom_range(0, 1) == 1), int'($urandom_range(0, 7)),
           "R5 random");
    end

    finish_run();
  end
endmodule